// File: doc/BRIEF.md
# Flash Status Bit Generator

This block is the status-reporting part of a NOR flash behavioural model. It tracks which embedded operation is running: plain read-array, a program, a sector erase, a suspended erase, or a program issued while an erase is suspended. On every read strobe it either passes the array word through or returns a status byte. The status byte carries two toggle bits and a sticky timeout flag. The surrounding model decodes the full command sequences, owns the array storage, and gives this block one-cycle command events, the array word for the read address, and an operation-done strobe.

One toggle bit (bit 6) flips on each status read while an operation is actually running. It freezes while the erase is suspended. The other toggle bit (bit 2) flips only on reads whose address falls inside a sector marked for erasure. It flips both while that erase runs and while it is suspended, so neither bit alone tells the full story.

A program that would need to raise a 0 bit back to 1 never completes. It stalls, a clock-driven pulse counter runs out, and bit 5 sets. A reset command then leaves the timed-out program. It returns to read-array, or to suspended-erase reading when the program was issued under a suspended erase.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `rd_data` is 0x00 and `wr_commit` is 0. In read-array mode, a read strobe loads `arr_data` into `rd_data`, and the value is visible after the clock edge that samples the strobe.
- R2: While a program, an erase or a program-under-suspend is running, every read returns the status byte. Its layout is: bit 6 = run toggle, bit 5 = timeout flag, bit 2 = sector toggle, and bits 7, 4, 3, 1 and 0 = 0.
- R3: The run toggle (bit 6) inverts after every status read while a program or erase is running, including a program under suspend. It holds its value across reads while the erase is suspended.
- R4: The sector toggle (bit 2) inverts after a read only when three things are true: the read address lies in a sector selected for erasure, the mode is erase, suspended erase or program-under-suspend, and a status byte is returned. It does not change on reads outside the selected sectors, nor during a program started from read-array.
- R5: While an erase is suspended, a read inside a selected sector returns the status byte. A read outside the selected sectors returns `arr_data`.
- R6: An erase command loads the sector-selection mask from `erase_mask`, where bit i stands for sector i and the sector is the top SECT_W bits of the address. An operation-done strobe during an erase clears the mask and returns to read-array.
- R7: Suspend is accepted only during an erase, and resume only during a suspended erase. A program command during a suspended erase starts a program-under-suspend. When that program completes, the mode goes back to suspended erase.
- R8: A program whose requested word has a 1 where the old word has a 0 stalls, and operation-done is ignored while it stalls. The timeout flag sets after PULSE_LIMIT clocks of stall: a read at the PULSE_LIMIT-th edge after the command still shows bit 5 = 0, and a read at the next edge shows 1. The flag stays set until a reset command.
- R9: A program that does not stall completes on operation-done. It pulses `wr_commit` for exactly one cycle, with `wr_data` equal to the requested word. A stalled program never raises `wr_commit`, so no array bit goes from 0 to 1.
- R10: A reset command given after a timeout clears bit 5 and both toggles. It returns a stalled program to read-array, and a stalled program-under-suspend to suspended erase. A reset command given without a timeout has no effect.
- R11: Both toggles clear when a program or erase starts from read-array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read address; top SECT_W bits select the sector |
| arr_data | input | 8 | Array word at the read address |
| cmd_prog | input | 1 | Program command event |
| prog_new | input | 8 | Word requested by the program |
| prog_old | input | 8 | Word currently stored at the program target |
| cmd_erase | input | 1 | Sector-erase command event |
| erase_mask | input | 2**SECT_W | Sectors selected by the erase command |
| cmd_suspend | input | 1 | Erase-suspend command event |
| cmd_resume | input | 1 | Erase-resume command event |
| cmd_reset | input | 1 | Reset command event |
| op_done | input | 1 | Embedded-operation finished strobe |
| rd_data | output | 8 | Read result: array word or status byte |
| wr_commit | output | 1 | One-cycle pulse when a program may write the array |
| wr_data | output | 8 | Word to be written with `wr_commit` |

## Verification
The bench builds the block with a 12-bit address, 3 sector bits and PULSE_LIMIT = 4. The four-clock limit puts the timeout boundary within a handful of idle cycles. That makes it cheap to read bit 5 at the last clean edge and at the first flagged edge, both for a program started from read-array and for one started under a suspended erase. Eight sectors of 512 words let the bench mix reads inside and outside the selection mask, so the sector toggle is seen both moving and holding during a running erase, a suspended erase and a program-under-suspend.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

   typedef enum logic [2:0] {
      MODE_READ    = 3'd0,
      MODE_PROG    = 3'd1,
      MODE_ERASE   = 3'd2,
      MODE_SUSP    = 3'd3,
      MODE_SUSPPRG = 3'd4
   } fsg_mode_t;

   localparam int unsigned BYTE_W = 8;

   localparam int unsigned BIT_RUN_TOG = 6;
   localparam int unsigned BIT_TIMEOUT = 5;
   localparam int unsigned BIT_SEC_TOG = 2;

   function automatic logic [BYTE_W-1:0] status_byte(input logic run_t,
                                                     input logic tout,
                                                     input logic sec_t);
      logic [BYTE_W-1:0] b;
      b = '0;
      b[BIT_RUN_TOG] = run_t;
      b[BIT_TIMEOUT] = tout;
      b[BIT_SEC_TOG] = sec_t;
      return b;
   endfunction

endpackage

// File: rtl/fsg_mode_ctrl.sv
module fsg_mode_ctrl
   import fsg_pkg::*;
#(
   parameter int unsigned PULSE_LIMIT = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_prog,
   input  logic [BYTE_W-1:0] prog_new,
   input  logic [BYTE_W-1:0] prog_old,
   input  logic              cmd_erase,
   input  logic              cmd_suspend,
   input  logic              cmd_resume,
   input  logic              cmd_reset,
   input  logic              op_done,
   output fsg_mode_t         mode,
   output logic              timed_out,
   output logic              tog_clr,
   output logic              erase_start,
   output logic              erase_end,
   output logic              wr_commit,
   output logic [BYTE_W-1:0] wr_data
);

   localparam int unsigned CNT_W = $clog2(PULSE_LIMIT + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_LIMIT - 1);

   logic              stalled;
   logic [CNT_W-1:0]  pulse_cnt;
   logic [BYTE_W-1:0] new_q;
   logic              raise_bit;
   logic              prog_running;
   logic              leave_on_reset;

   assign raise_bit      = |(prog_new & ~prog_old);
   assign prog_running   = (mode == MODE_PROG) || (mode == MODE_SUSPPRG);
   assign leave_on_reset = prog_running && timed_out && cmd_reset;

   assign erase_start = (mode == MODE_READ) && !cmd_prog && cmd_erase;
   assign erase_end   = (mode == MODE_ERASE) && !cmd_suspend && op_done;
   assign tog_clr     = ((mode == MODE_READ) && (cmd_prog || cmd_erase)) ||
                        leave_on_reset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= MODE_READ;
         stalled   <= 1'b0;
         pulse_cnt <= '0;
         timed_out <= 1'b0;
         new_q     <= '0;
         wr_commit <= 1'b0;
         wr_data   <= '0;
      end else begin
         wr_commit <= 1'b0;
         if (stalled && !timed_out) begin
            if (pulse_cnt == CNT_LAST) begin
               timed_out <= 1'b1;
            end else begin
               pulse_cnt <= pulse_cnt + 1'b1;
            end
         end
         unique case (mode)
            MODE_READ: begin
               if (cmd_prog) begin
                  mode      <= MODE_PROG;
                  new_q     <= prog_new;
                  stalled   <= raise_bit;
                  pulse_cnt <= '0;
               end else if (cmd_erase) begin
                  mode <= MODE_ERASE;
               end
            end
            MODE_ERASE: begin
               if (cmd_suspend) begin
                  mode <= MODE_SUSP;
               end else if (op_done) begin
                  mode <= MODE_READ;
               end
            end
            MODE_SUSP: begin
               if (cmd_resume) begin
                  mode <= MODE_ERASE;
               end else if (cmd_prog) begin
                  mode      <= MODE_SUSPPRG;
                  new_q     <= prog_new;
                  stalled   <= raise_bit;
                  pulse_cnt <= '0;
               end
            end
            MODE_PROG, MODE_SUSPPRG: begin
               if (leave_on_reset) begin
                  mode      <= (mode == MODE_PROG) ? MODE_READ : MODE_SUSP;
                  timed_out <= 1'b0;
                  stalled   <= 1'b0;
                  pulse_cnt <= '0;
               end else if (op_done && !stalled) begin
                  mode      <= (mode == MODE_PROG) ? MODE_READ : MODE_SUSP;
                  wr_commit <= 1'b1;
                  wr_data   <= new_q;
               end
            end
            default: mode <= MODE_READ;
         endcase
      end
   end

endmodule

// File: rtl/fsg_sector_sel.sv
module fsg_sector_sel #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned SECT_W = 3,
   localparam int unsigned NSECT = 1 << SECT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic [NSECT-1:0]  load_mask,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [NSECT-1:0]  mask,
   output logic              hit
);

   for (genvar s = 0; s < NSECT; s++) begin : g_sect
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask[s] <= 1'b0;
         end else if (clear) begin
            mask[s] <= 1'b0;
         end else if (load) begin
            mask[s] <= load_mask[s];
         end
      end
   end

   if (SECT_W == 0) begin : g_single
      assign hit = mask[0];
   end else begin : g_multi
      logic [SECT_W-1:0] sect_idx;
      assign sect_idx = rd_addr[ADDR_W-1 -: SECT_W];
      assign hit      = mask[sect_idx];
   end

endmodule

// File: rtl/fsg_read_path.sv
module fsg_read_path
   import fsg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic [BYTE_W-1:0] arr_data,
   input  fsg_mode_t         mode,
   input  logic              timed_out,
   input  logic              hit,
   input  logic              tog_clr,
   output logic              run_tog,
   output logic              sec_tog,
   output logic [BYTE_W-1:0] rd_data
);

   logic show_status;
   logic flip_run;
   logic flip_sec;
   logic [BYTE_W-1:0] stat;

   always_comb begin
      show_status = 1'b0;
      flip_run    = 1'b0;
      flip_sec    = 1'b0;
      unique case (mode)
         MODE_PROG: begin
            show_status = 1'b1;
            flip_run    = 1'b1;
         end
         MODE_ERASE, MODE_SUSPPRG: begin
            show_status = 1'b1;
            flip_run    = 1'b1;
            flip_sec    = hit;
         end
         MODE_SUSP: begin
            show_status = hit;
            flip_sec    = hit;
         end
         default: ;
      endcase
   end

   assign stat = status_byte(run_tog, timed_out, sec_tog);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_tog <= 1'b0;
         sec_tog <= 1'b0;
         rd_data <= '0;
      end else begin
         if (rd_stb) begin
            rd_data <= show_status ? stat : arr_data;
         end
         if (tog_clr) begin
            run_tog <= 1'b0;
            sec_tog <= 1'b0;
         end else if (rd_stb) begin
            if (flip_run) run_tog <= ~run_tog;
            if (flip_sec) sec_tog <= ~sec_tog;
         end
      end
   end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import fsg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SECT_W      = 3,
   parameter int unsigned PULSE_LIMIT = 4096,
   localparam int unsigned NSECT = 1 << SECT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        arr_data,
   input  logic              cmd_prog,
   input  logic [7:0]        prog_new,
   input  logic [7:0]        prog_old,
   input  logic              cmd_erase,
   input  logic [NSECT-1:0]  erase_mask,
   input  logic              cmd_suspend,
   input  logic              cmd_resume,
   input  logic              cmd_reset,
   input  logic              op_done,
   output logic [7:0]        rd_data,
   output logic              wr_commit,
   output logic [7:0]        wr_data
);

   if (SECT_W > ADDR_W) begin : g_bad_sect
      $error("SECT_W must not exceed ADDR_W");
   end
   if (SECT_W > 6) begin : g_bad_nsect
      $error("SECT_W above 6 makes the selection mask too wide");
   end
   if (PULSE_LIMIT < 2) begin : g_bad_limit
      $error("PULSE_LIMIT must be at least 2");
   end

   fsg_mode_t        mode;
   logic             timed_out;
   logic             tog_clr;
   logic             erase_start;
   logic             erase_end;
   logic [NSECT-1:0] sect_mask;
   logic             sect_hit;
   logic             run_tog;
   logic             sec_tog;

   fsg_mode_ctrl #(
      .PULSE_LIMIT (PULSE_LIMIT)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_prog    (cmd_prog),
      .prog_new    (prog_new),
      .prog_old    (prog_old),
      .cmd_erase   (cmd_erase),
      .cmd_suspend (cmd_suspend),
      .cmd_resume  (cmd_resume),
      .cmd_reset   (cmd_reset),
      .op_done     (op_done),
      .mode        (mode),
      .timed_out   (timed_out),
      .tog_clr     (tog_clr),
      .erase_start (erase_start),
      .erase_end   (erase_end),
      .wr_commit   (wr_commit),
      .wr_data     (wr_data)
   );

   fsg_sector_sel #(
      .ADDR_W (ADDR_W),
      .SECT_W (SECT_W)
   ) u_sect (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (erase_start),
      .clear     (erase_end),
      .load_mask (erase_mask),
      .rd_addr   (rd_addr),
      .mask      (sect_mask),
      .hit       (sect_hit)
   );

   fsg_read_path u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_stb    (rd_stb),
      .arr_data  (arr_data),
      .mode      (mode),
      .timed_out (timed_out),
      .hit       (sect_hit),
      .tog_clr   (tog_clr),
      .run_tog   (run_tog),
      .sec_tog   (sec_tog),
      .rd_data   (rd_data)
   );

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
   import fsg_pkg::*;
#(
   parameter int unsigned NSECT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_stb,
   input logic [7:0]       arr_data,
   input logic [7:0]       rd_data,
   input logic             wr_commit,
   input logic             cmd_reset,
   input fsg_mode_t        mode,
   input logic             timed_out,
   input logic             run_tog,
   input logic [NSECT-1:0] sect_mask
);

   assert_read_array_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mode == MODE_READ) |=> rd_data == $past(arr_data));

   assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SUSP && $past(mode) == MODE_SUSP) |-> $stable(run_tog));

   assert_mask_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_READ) |-> sect_mask == '0);

   assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (timed_out && !cmd_reset) |=> timed_out);

   assert_commit_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |=> !wr_commit);

   assert_no_timeout_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_PROG && mode != MODE_SUSPPRG) |-> !timed_out);

endmodule

bind flash_status_gen fsg_checker #(
   .NSECT (NSECT)
) u_fsg_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_stb    (rd_stb),
   .arr_data  (arr_data),
   .rd_data   (rd_data),
   .wr_commit (wr_commit),
   .cmd_reset (cmd_reset),
   .mode      (mode),
   .timed_out (timed_out),
   .run_tog   (run_tog),
   .sect_mask (sect_mask)
);

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;

   localparam int unsigned ADDR_W = 12;
   localparam int unsigned SECT_W = 3;
   localparam int unsigned LIMIT  = 4;
   localparam int unsigned NSECT  = 1 << SECT_W;

   localparam logic [2:0] OP_NOP = 3'd0, OP_RD = 3'd1, OP_PRG = 3'd2,
                          OP_ERS = 3'd3, OP_SUS = 3'd4, OP_RES = 3'd5,
                          OP_RST = 3'd6, OP_DONE = 3'd7;

   // vector: op[43:41] addr[40:29] d[28:21] aux[20:13] chk[12] req[11:8] exp[7:0]
   function automatic logic [43:0] mk(input logic [2:0] op, input logic [11:0] a,
                                      input logic [7:0] d, input logic [7:0] x,
                                      input logic c, input logic [3:0] r,
                                      input logic [7:0] e);
      return {op, a, d, x, c, r, e};
   endfunction

   localparam int NV = 52;
   localparam logic [43:0] VEC [NV] = '{
      mk(OP_RD,  12'h000, 8'h5A, 8'h00, 1, 1, 8'h5A),   // R1 read-array
      mk(OP_ERS, 12'h000, 8'h00, 8'h04, 0, 6, 8'h00),   // R6 select sector 2
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 2, 8'h00),   // R2 R11
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 4, 8'h44),   // R4 in-sector
      mk(OP_RD,  12'h000, 8'hEE, 8'h00, 1, 4, 8'h00),   // R4 out-of-sector
      mk(OP_RD,  12'h000, 8'hEE, 8'h00, 1, 3, 8'h40),   // R3
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 3, 8'h00),   // R3
      mk(OP_SUS, 12'h000, 8'h00, 8'h00, 0, 7, 8'h00),   // R7
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 5, 8'h44),   // R5 status in sector
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 3, 8'h40),   // R3 bit6 held
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 4, 8'h44),   // R4 bit2 moves
      mk(OP_RD,  12'h000, 8'hA5, 8'h00, 1, 5, 8'hA5),   // R5 array outside
      mk(OP_PRG, 12'h000, 8'hF0, 8'hFF, 0, 7, 8'h00),   // R7 program under suspend
      mk(OP_RD,  12'h000, 8'hEE, 8'h00, 1, 3, 8'h40),   // R3
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 4, 8'h00),   // R4
      mk(OP_DONE,12'h000, 8'h00, 8'h00, 0, 7, 8'h00),   // R7 back to suspend
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 7, 8'h44),   // R7
      mk(OP_RD,  12'h000, 8'h3B, 8'h00, 1, 7, 8'h3B),   // R7 array outside
      mk(OP_RES, 12'h000, 8'h00, 8'h00, 0, 7, 8'h00),   // R7 resume
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 7, 8'h40),   // R7
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 3, 8'h04),   // R3
      mk(OP_RST, 12'h000, 8'h00, 8'h00, 0, 10, 8'h00),  // R10 ignored
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 10, 8'h40),  // R10
      mk(OP_DONE,12'h000, 8'h00, 8'h00, 0, 6, 8'h00),   // R6 erase ends
      mk(OP_RD,  12'h400, 8'h3C, 8'h00, 1, 6, 8'h3C),   // R6
      mk(OP_PRG, 12'h000, 8'hFF, 8'h00, 0, 8, 8'h00),   // R8 stalls
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 11, 8'h00),  // R11
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 4, 8'h40),   // R4 no bit2
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 8, 8'h00),   // R8
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 8, 8'h40),   // R8 edge L: clean
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 8, 8'h20),   // R8 edge L+1: flagged
      mk(OP_DONE,12'h000, 8'h00, 8'h00, 0, 8, 8'h00),   // R8 ignored
      mk(OP_RD,  12'h400, 8'hEE, 8'h00, 1, 8, 8'h60),   // R8
      mk(OP_RST, 12'h000, 8'h00, 8'h00, 0, 10, 8'h00),  // R10
      mk(OP_RD,  12'h000, 8'h77, 8'h00, 1, 10, 8'h77),  // R10 read-array
      mk(OP_ERS, 12'h000, 8'h00, 8'h02, 0, 6, 8'h00),   // R6 sector 1
      mk(OP_SUS, 12'h000, 8'h00, 8'h00, 0, 7, 8'h00),   // R7
      mk(OP_PRG, 12'h000, 8'h0F, 8'h00, 0, 8, 8'h00),   // R8 stall under suspend
      mk(OP_NOP, 12'h000, 8'h00, 8'h00, 0, 8, 8'h00),
      mk(OP_NOP, 12'h000, 8'h00, 8'h00, 0, 8, 8'h00),
      mk(OP_NOP, 12'h000, 8'h00, 8'h00, 0, 8, 8'h00),
      mk(OP_RD,  12'h200, 8'hEE, 8'h00, 1, 8, 8'h00),   // R8 edge L
      mk(OP_RD,  12'h200, 8'hEE, 8'h00, 1, 8, 8'h64),   // R8 edge L+1
      mk(OP_RST, 12'h000, 8'h00, 8'h00, 0, 10, 8'h00),  // R10 to suspend
      mk(OP_RD,  12'h200, 8'hEE, 8'h00, 1, 10, 8'h00),  // R10 cleared
      mk(OP_RD,  12'h000, 8'h99, 8'h00, 1, 10, 8'h99),  // R10 suspend read
      mk(OP_RES, 12'h000, 8'h00, 8'h00, 0, 7, 8'h00),   // R7
      mk(OP_RD,  12'h200, 8'hEE, 8'h00, 1, 4, 8'h04),   // R4
      mk(OP_RD,  12'h600, 8'hEE, 8'h00, 1, 4, 8'h40),   // R4 sector 3 not selected
      mk(OP_RD,  12'h200, 8'hEE, 8'h00, 1, 4, 8'h00),   // R4
      mk(OP_DONE,12'h000, 8'h00, 8'h00, 0, 6, 8'h00),   // R6
      mk(OP_RD,  12'h200, 8'h11, 8'h00, 1, 6, 8'h11)    // R6
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_stb = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [7:0]        arr_data = '0;
   logic              cmd_prog = 1'b0;
   logic [7:0]        prog_new = '0;
   logic [7:0]        prog_old = '0;
   logic              cmd_erase = 1'b0;
   logic [NSECT-1:0]  erase_mask = '0;
   logic              cmd_suspend = 1'b0;
   logic              cmd_resume = 1'b0;
   logic              cmd_reset = 1'b0;
   logic              op_done = 1'b0;
   logic [7:0]        rd_data;
   logic              wr_commit;
   logic [7:0]        wr_data;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   flash_status_gen #(
      .ADDR_W (ADDR_W), .SECT_W (SECT_W), .PULSE_LIMIT (LIMIT)
   ) u_flash_status_gen (
      .clk (clk), .rst_n (rst_n), .rd_stb (rd_stb), .rd_addr (rd_addr),
      .arr_data (arr_data), .cmd_prog (cmd_prog), .prog_new (prog_new),
      .prog_old (prog_old), .cmd_erase (cmd_erase), .erase_mask (erase_mask),
      .cmd_suspend (cmd_suspend), .cmd_resume (cmd_resume),
      .cmd_reset (cmd_reset), .op_done (op_done), .rd_data (rd_data),
      .wr_commit (wr_commit), .wr_data (wr_data)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // starts and ends at a falling edge; one rising edge in between
   task automatic do_op(input logic [2:0] op, input logic [11:0] a,
                        input logic [7:0] d, input logic [7:0] x);
      rd_addr = a;
      case (op)
         OP_RD:   begin rd_stb = 1'b1; arr_data = d; end
         OP_PRG:  begin cmd_prog = 1'b1; prog_new = d; prog_old = x; end
         OP_ERS:  begin cmd_erase = 1'b1; erase_mask = x; end
         OP_SUS:  cmd_suspend = 1'b1;
         OP_RES:  cmd_resume = 1'b1;
         OP_RST:  cmd_reset = 1'b1;
         OP_DONE: op_done = 1'b1;
         default: ;
      endcase
      @(posedge clk);
      @(negedge clk);
      rd_stb = 1'b0; cmd_prog = 1'b0; cmd_erase = 1'b0; cmd_suspend = 1'b0;
      cmd_resume = 1'b0; cmd_reset = 1'b0; op_done = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset rd_data", rd_data, 8'h00);
      check("R1 reset wr_commit", {7'd0, wr_commit}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [43:0] v;
         v = VEC[i];
         do_op(v[43:41], v[40:29], v[28:21], v[20:13]);
         if (v[12]) begin
            checks++;
            if (rd_data !== v[7:0]) begin
               errors++;
               $display("FAIL R%0d vector %0d: actual=%02h expected=%02h",
                        v[11:8], i, rd_data, v[7:0]);
            end
         end
      end

      // R9 clean program commits once with the requested word
      do_op(OP_PRG, 12'h000, 8'h31, 8'hF3);
      check("R9 no commit before done", {7'd0, wr_commit}, 8'h00);
      do_op(OP_DONE, 12'h000, 8'h00, 8'h00);
      check("R9 commit pulse", {7'd0, wr_commit}, 8'h01);
      check("R9 commit data", wr_data, 8'h31);
      do_op(OP_NOP, 12'h000, 8'h00, 8'h00);
      check("R9 commit one cycle", {7'd0, wr_commit}, 8'h00);

      // R9 stalled program never commits
      do_op(OP_PRG, 12'h000, 8'h02, 8'h01);
      do_op(OP_DONE, 12'h000, 8'h00, 8'h00);
      check("R9 stalled no commit", {7'd0, wr_commit}, 8'h00);
      repeat (LIMIT + 1) do_op(OP_NOP, 12'h000, 8'h00, 8'h00);
      do_op(OP_DONE, 12'h000, 8'h00, 8'h00);
      check("R9 timed-out no commit", {7'd0, wr_commit}, 8'h00);
      do_op(OP_RD, 12'h000, 8'hEE, 8'h00);
      check("R8 flag held", rd_data & 8'h20, 8'h20);
      do_op(OP_RST, 12'h000, 8'h00, 8'h00);
      check("R10 no commit on reset", {7'd0, wr_commit}, 8'h00);

      // R1 hardware reset mid-erase returns to read-array
      do_op(OP_ERS, 12'h000, 8'h00, 8'h04);
      do_op(OP_RD, 12'h400, 8'hEE, 8'h00);
      check("R2 erase status", rd_data, 8'h00);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 rd_data after reset", rd_data, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      do_op(OP_RD, 12'h400, 8'h5E, 8'h00);
      check("R1 read-array after reset", rd_data, 8'h5E);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule